// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block is the slave side of a stereo audio serial link. An external master drives a bit clock, a channel-select clock and one serial data line. All three are brought into the system clock domain and rising bit-clock edges are detected there. The incoming bits are then assembled into signed parallel samples, one for the left channel and one for the right. Every edge of the channel-select line ends the current word.

A control input picks the framing. In I2S framing the data runs one bit behind the channel-select line. In MSB-justified framing the MSB starts on the channel-select edge. In LSB-justified framing the LSB falls on the last bit before the next channel-select edge, so the start of the word is found by counting back from that edge. A second input sets the word length.

Each sample is sign-extended to the full output width. A finished left/right pair is shown on two parallel outputs together with a one-cycle valid strobe. An overrun pulse marks a pair that replaced one the consumer never acknowledged. The system clock must run at least four times faster than the bit clock.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid` and `overrun` are 0 and `out_left` and `out_right` are all zeros.
- R2: With `fmt_sel`=0 (I2S), a low channel-select level marks the left channel. The bit sampled on the rising bit-clock edge that first sees a channel-select change is the last bit of the word being closed. The new word's MSB is the bit sampled on the next rising edge.
- R3: With `fmt_sel`=1 (MSB-justified; code 3 behaves the same way), a high channel-select level marks the left channel. The bit sampled on the rising edge that sees the channel-select change is the MSB of the new word.
- R4: With `fmt_sel`=2 (LSB-justified), a high channel-select level marks the left channel. The sample is formed from the last `word_bits` bits sampled before the closing channel-select change, with the LSB last. Earlier bits of the slot have no effect.
- R5: In the MSB-first framings, bits received after `word_bits` bits of a word are ignored.
- R6: In the MSB-first framings, a word that ends with fewer than `word_bits` bits has its missing low bits filled with zeros.
- R7: Every sample is sign-extended from bit `word_bits`-1 to the full output width. A `word_bits` of 0 or above the output width is treated as the full width.
- R8: `out_valid` pulses for exactly one system cycle when a right word completes and the left word of the same frame came before it. `out_left` and `out_right` change only in that cycle.
- R9: When a new pair is presented while the previous pair is still unacknowledged (`pair_ack` low since it was presented), `overrun` pulses together with `out_valid`.
- R10: A word that did not begin at a channel-select change after reset is discarded. A right word without a preceding left word produces no output.
- R11: The left and right slots may have different lengths (a channel-select duty cycle other than 50%). Each word is still recovered as R2 to R6 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 MSB-justified, 2 LSB-justified, 3 as 1 |
| word_bits | input | $clog2(W+1) (6) | Word length in bits |
| bclk_in | input | 1 | External serial bit clock |
| lrck_in | input | 1 | External channel-select clock |
| sd_in | input | 1 | External serial data |
| pair_ack | input | 1 | Consumer has taken the presented pair |
| out_valid | output | 1 | One-cycle strobe for a new sample pair |
| out_left | output | W (32) | Sign-extended left sample |
| out_right | output | W (32) | Sign-extended right sample |
| overrun | output | 1 | Pulses when an unacknowledged pair is replaced |

## Verification
Internal errors in this block become visible at the ports one frame later: the next completed right word brings out the fault. A bit counter that slips moves every bit of the sample, so wrong magnitudes appear in the first pair. A wrong channel decision or a wrong word-started flag produces an extra pair or a missing pair; the bench checks the pair count after each stream, including the lead-in partial words that must be discarded. A stale acknowledge flag shows up as a missing or spurious overrun on the second unacknowledged frame.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_MSBJ = 2'd1,
        FMT_LSBJ = 2'd2
    } rx_fmt_e;

    // One detected rising edge of the bit clock, with the line levels sampled there
    typedef struct packed {
        logic fire;
        logic lr;
        logic dat;
    } bit_evt_t;

    function automatic logic fmt_msb_first(rx_fmt_e f);
        return f != FMT_LSBJ;
    endfunction

    // I2S: low level is left; justified framings: high level is left
    function automatic logic fmt_is_left(rx_fmt_e f, logic lr);
        return (f == FMT_I2S) ? ~lr : lr;
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync
    import aud_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_in,
    input  logic     lrck_in,
    input  logic     sd_in,
    output bit_evt_t evt
);
    localparam int NL   = 3;
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][NL-1:0] stg;
    logic                      bclk_q;

    // All three lines go through the same depth so they stay aligned
    always_ff @(posedge clk) begin
        if (rst) begin
            stg    <= '0;
            bclk_q <= 1'b0;
        end else begin
            stg[0] <= {bclk_in, lrck_in, sd_in};
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
            bclk_q <= stg[LAST][2];
        end
    end

    always_comb begin
        evt.fire = stg[LAST][2] & ~bclk_q;
        evt.lr   = stg[LAST][1];
        evt.dat  = stg[LAST][0];
    end

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_rx_pkg::*;
#(
    parameter  int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  rx_fmt_e       fmt,
    input  logic [CW-1:0] wlen,
    input  bit_evt_t      evt,
    output logic          wd_done,
    output logic          wd_left,
    output logic [W-1:0]  wd_val
);
    logic          primed;
    logic          lr_prev;
    logic          in_word;
    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    logic          chg;
    logic          msbf;
    logic          room;
    logic [CW-1:0] ins_pos;
    logic [CW-1:0] shamt;
    logic [W-1:0]  sh_ins;
    logic [W-1:0]  close_src;
    logic [W-1:0]  aligned;

    always_comb begin
        msbf    = fmt_msb_first(fmt);
        chg     = evt.fire && primed && (evt.lr != lr_prev);
        room    = cnt < wlen;
        ins_pos = CW'(W - 1) - cnt;
        sh_ins  = room ? (sh | (W'(evt.dat) << ins_pos)) : sh;
        // I2S: the bit on the boundary edge still belongs to the closing word
        close_src = (fmt == FMT_I2S) ? sh_ins : sh;
        shamt     = CW'(W) - wlen;
        if (msbf) begin
            aligned = W'($signed(close_src) >>> shamt);
        end else begin
            aligned = W'($signed(close_src << shamt) >>> shamt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed  <= 1'b0;
            lr_prev <= 1'b0;
            in_word <= 1'b0;
            sh      <= '0;
            cnt     <= '0;
            wd_done <= 1'b0;
            wd_left <= 1'b0;
            wd_val  <= '0;
        end else begin
            wd_done <= 1'b0;
            if (evt.fire) begin
                primed  <= 1'b1;
                lr_prev <= evt.lr;
                if (chg) begin
                    in_word <= 1'b1;
                    wd_done <= in_word;
                    wd_left <= fmt_is_left(fmt, lr_prev);
                    wd_val  <= aligned;
                    case (fmt)
                        FMT_I2S: begin
                            sh  <= '0;
                            cnt <= '0;
                        end
                        FMT_LSBJ: begin
                            sh  <= W'(evt.dat);
                            cnt <= '0;
                        end
                        default: begin
                            sh  <= W'(evt.dat) << (W - 1);
                            cnt <= CW'(1);
                        end
                    endcase
                end else if (msbf) begin
                    sh <= sh_ins;
                    if (room) begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    sh <= {sh[W-2:0], evt.dat};
                end
            end
        end
    end

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wd_done,
    input  logic         wd_left,
    input  logic [W-1:0] wd_val,
    input  logic         pair_ack,
    output logic         out_valid,
    output logic [W-1:0] out_left,
    output logic [W-1:0] out_right,
    output logic         overrun
);
    logic         have_left;
    logic [W-1:0] left_hold;
    logic         pending;
    logic         new_pair;

    always_comb begin
        new_pair = wd_done && !wd_left && have_left;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_left <= 1'b0;
            left_hold <= '0;
            pending   <= 1'b0;
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
            overrun   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            overrun   <= 1'b0;
            if (wd_done) begin
                if (wd_left) begin
                    left_hold <= wd_val;
                    have_left <= 1'b1;
                end else begin
                    have_left <= 1'b0;
                end
            end
            if (new_pair) begin
                out_left  <= left_hold;
                out_right <= wd_val;
                out_valid <= 1'b1;
                overrun   <= pending && !pair_ack;
                pending   <= 1'b1;
            end else if (pair_ack) begin
                pending <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import aud_rx_pkg::*;
#(
    parameter  int W           = 32,
    parameter  int SYNC_STAGES = 2,
    localparam int CW          = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    fmt_sel,
    input  logic [CW-1:0] word_bits,
    input  logic          bclk_in,
    input  logic          lrck_in,
    input  logic          sd_in,
    input  logic          pair_ack,
    output logic          out_valid,
    output logic [W-1:0]  out_left,
    output logic [W-1:0]  out_right,
    output logic          overrun
);
    rx_fmt_e       fmt;
    logic [CW-1:0] wl_eff;
    bit_evt_t      evt;
    logic          wd_done;
    logic          wd_left;
    logic [W-1:0]  wd_val;

    always_comb begin
        fmt    = rx_fmt_e'(fmt_sel);
        wl_eff = (word_bits == '0 || word_bits > CW'(W)) ? CW'(W) : word_bits;
    end

    aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .bclk_in (bclk_in),
        .lrck_in (lrck_in),
        .sd_in   (sd_in),
        .evt     (evt)
    );

    aud_rx_deser #(.W(W)) u_deser (
        .clk     (clk),
        .rst     (rst),
        .fmt     (fmt),
        .wlen    (wl_eff),
        .evt     (evt),
        .wd_done (wd_done),
        .wd_left (wd_left),
        .wd_val  (wd_val)
    );

    aud_rx_pair #(.W(W)) u_pair (
        .clk       (clk),
        .rst       (rst),
        .wd_done   (wd_done),
        .wd_left   (wd_left),
        .wd_val    (wd_val),
        .pair_ack  (pair_ack),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right),
        .overrun   (overrun)
    );

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
    parameter  int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] word_bits,
    input logic          out_valid,
    input logic [W-1:0]  out_left,
    input logic [W-1:0]  out_right,
    input logic          overrun
);
    logic                rst_q;
    logic [CW-1:0]       top_bit;
    logic signed [W-1:0] hi_l;
    logic signed [W-1:0] hi_r;

    always_comb begin
        top_bit = (word_bits == '0 || word_bits > CW'(W)) ? CW'(W - 1) : word_bits - 1'b1;
        hi_l    = $signed(out_left) >>> top_bit;
        hi_r    = $signed(out_right) >>> top_bit;
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            assert_reset_state_R1: assert (!out_valid && !overrun && out_left == '0 && out_right == '0)
                else $error("outputs not cleared after reset");
        end
    end

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_out_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_left) && $stable(out_right)));

    assert_overrun_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
        overrun |-> out_valid);

    assert_sign_extended_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((hi_l == '0 || hi_l == '1) && (hi_r == '0 || hi_r == '1)));

endmodule

bind audio_serial_rx aud_rx_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .word_bits (word_bits),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .overrun   (overrun)
);

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'd0;
    logic [5:0]  word_bits = 6'd16;
    logic        bclk_in = 1'b0;
    logic        lrck_in = 1'b0;
    logic        sd_in = 1'b0;
    logic        pair_ack = 1'b1;
    logic        out_valid;
    logic [31:0] out_left;
    logic [31:0] out_right;
    logic        overrun;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] tx_l [8];
    logic [31:0] tx_r [8];
    logic [31:0] got_l [8];
    logic [31:0] got_r [8];
    int          got_n = 0;
    int          ovr_n = 0;
    int          wide_n = 0;
    logic        prev_valid = 1'b0;
    int          cur_fmt = 0;
    logic        carry = 1'b0;

    always #10 clk = ~clk;

    audio_serial_rx dut (
        .clk       (clk),
        .rst       (rst),
        .fmt_sel   (fmt_sel),
        .word_bits (word_bits),
        .bclk_in   (bclk_in),
        .lrck_in   (lrck_in),
        .sd_in     (sd_in),
        .pair_ack  (pair_ack),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right),
        .overrun   (overrun)
    );

    // Capture pairs away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (got_n < 8) begin
                    got_l[got_n] = out_left;
                    got_r[got_n] = out_right;
                end
                got_n++;
                if (overrun) ovr_n++;
                if (prev_valid) wide_n++;
            end
            prev_valid = out_valid;
        end else begin
            prev_valid = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_val(input int fmt, input int wl, input int nb, input logic [31:0] w);
        longint v;
        longint one;
        one = 64'sd1;
        v = longint'(w) & ((one << nb) - 1);
        if (fmt != 2) begin
            if (nb >= wl) v = v >>> (nb - wl);
            else          v = v << (wl - nb);
        end
        v = v & ((one << wl) - 1);
        v = (v ^ (one << (wl - 1))) - (one << (wl - 1));
        return v[31:0];
    endfunction

    task automatic do_reset(input int fmt, input int wl);
        rst = 1'b1;
        fmt_sel = 2'(fmt);
        word_bits = 6'(wl);
        cur_fmt = fmt;
        bclk_in = 1'b0;
        lrck_in = (fmt == 0) ? 1'b0 : 1'b1;
        sd_in = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // One bit-clock period; lines change with the falling edge
    task automatic put(input logic lr, input logic d);
        logic s;
        if (cur_fmt == 0) begin
            s = carry;
            carry = d;
        end else begin
            s = d;
        end
        bclk_in = 1'b0;
        lrck_in = lr;
        sd_in = s;
        repeat (4) @(negedge clk);
        bclk_in = 1'b1;
        repeat (4) @(negedge clk);
        bclk_in = 1'b0;
    endtask

    task automatic slot(input logic lr, input int len, input int nb, input logic [31:0] w, input logic pad);
        for (int k = 0; k < len; k++) begin
            logic b;
            if (cur_fmt == 2) b = (k >= len - nb) ? w[len-1-k] : pad;
            else              b = (k < nb) ? w[nb-1-k] : pad;
            put(lr, b);
        end
    endtask

    task automatic run_case(input string req, input int fmt, input int wl, input int nfr,
                            input int sl_l, input int sl_r, input int nb, input logic pad,
                            input int exp_ovr);
        logic left_lvl;
        do_reset(fmt, wl);
        left_lvl = (fmt == 0) ? 1'b0 : 1'b1;
        got_n = 0;
        ovr_n = 0;
        carry = 1'b0;
        // Lead-in: partial left and an unpaired right, both must vanish (R10)
        for (int i = 0; i < 5; i++) put(left_lvl, 1'b1);
        slot(~left_lvl, sl_r, nb, 32'hFFFF_FFFF, pad);
        for (int f = 0; f < nfr; f++) begin
            slot(left_lvl, sl_l, nb, tx_l[f], pad);
            slot(~left_lvl, sl_r, nb, tx_r[f], pad);
        end
        slot(left_lvl, 3, 0, 32'h0, 1'b0);
        repeat (20) @(negedge clk);
        chk({req, " R10"}, "pair count", 32'(got_n), 32'(nfr));
        for (int f = 0; f < nfr && f < 8; f++) begin
            chk(req, "left sample", got_l[f], expect_val(fmt, wl, nb, tx_l[f]));
            chk(req, "right sample", got_r[f], expect_val(fmt, wl, nb, tx_r[f]));
        end
        chk({req, " R9"}, "overrun count", 32'(ovr_n), 32'(exp_ovr));
        if (nfr > 0) begin
            chk({req, " R8"}, "held left", out_left, expect_val(fmt, wl, nb, tx_l[nfr-1]));
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", 32'(out_valid), 32'd0);
        chk("R1", "left in reset", out_left, 32'd0);
        chk("R1", "right in reset", out_right, 32'd0);
        chk("R1", "overrun in reset", 32'(overrun), 32'd0);
    endtask

    task automatic t_i2s;
        tx_l[0] = 32'h0000_8001; tx_r[0] = 32'h0000_7FFE;
        tx_l[1] = 32'h0000_1234; tx_r[1] = 32'h0000_FEDC;
        run_case("R2 R7", 0, 16, 2, 16, 16, 16, 1'b0, 0);
    endtask

    task automatic t_msbj;
        tx_l[0] = 32'h00A5_5A3C; tx_r[0] = 32'h0012_3456;
        tx_l[1] = 32'h0080_0000; tx_r[1] = 32'h007F_FFFF;
        run_case("R3 R7", 1, 24, 2, 32, 32, 24, 1'b1, 0);
    endtask

    task automatic t_lsbj;
        tx_l[0] = 32'h000C_3A5F; tx_r[0] = 32'h0007_0001;
        tx_l[1] = 32'h0008_0000; tx_r[1] = 32'h000F_FFFF;
        run_case("R4 R7", 2, 20, 2, 32, 32, 20, 1'b1, 0);
    endtask

    task automatic t_long_word;
        // 24 bits sent, 16 kept
        tx_l[0] = 32'h00C3_5A17; tx_r[0] = 32'h0041_FF80;
        run_case("R5", 1, 16, 1, 32, 32, 24, 1'b1, 0);
    endtask

    task automatic t_short_word;
        // 16 bits sent into a 24-bit word
        tx_l[0] = 32'h0000_9ABC; tx_r[0] = 32'h0000_1357;
        run_case("R6", 1, 24, 1, 16, 16, 16, 1'b0, 0);
    endtask

    task automatic t_uneven;
        tx_l[0] = 32'h0002_ACE1; tx_r[0] = 32'h0001_5B3D;
        tx_l[1] = 32'h0003_0F0F; tx_r[1] = 32'h0000_F0F0;
        run_case("R11 R2", 0, 18, 2, 20, 28, 18, 1'b1, 0);
    endtask

    task automatic t_overrun;
        pair_ack = 1'b0;
        tx_l[0] = 32'h0000_0011; tx_r[0] = 32'h0000_0022;
        tx_l[1] = 32'h0000_0033; tx_r[1] = 32'h0000_0044;
        tx_l[2] = 32'h0000_0055; tx_r[2] = 32'h0000_0066;
        run_case("R9", 1, 16, 3, 16, 16, 16, 1'b0, 2);
        pair_ack = 1'b1;
    endtask

    initial begin
        t_reset();
        t_i2s();
        t_msbj();
        t_lsbj();
        t_long_word();
        t_short_word();
        t_uneven();
        t_overrun();
        chk("R8", "multi-cycle valid", 32'(wide_n), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule